// File: doc/BRIEF.md
# Condition Test and Loop-Branch Unit

This block decides the outcome of the flag-driven instructions in a processor's execute stage. It takes a 4-bit condition code, the four arithmetic flags (negative, zero, overflow, carry), an instruction kind, and the 32-bit counter register. It returns a taken indication, a byte result for the conditional-set kind, and an updated counter with a write-back strobe for the counted-loop kind. The block does not fetch the displacement or add it to the program counter. That work belongs to the surrounding pipeline, which only reads `out_taken`.

Each valid input is evaluated combinationally and captured in one output register stage, so its result appears on the cycle after the input. A two-state stage machine tracks whether the output stage holds a result. In `ST_IDLE`, no result is presented. In `ST_ISSUE`, a result is presented. The transition `GO_ISSUE` is taken from either state whenever `in_valid` is high, and `GO_IDLE` is taken from either state whenever it is low. Back-to-back valid inputs therefore stream through at one result per cycle.

Top module: `ccbr_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero and `out_valid` is 0.
- R2: `out_valid` is high exactly on the cycle after a cycle with `in_valid` high. After a cycle with `in_valid` low, `out_taken`, `out_illegal`, `out_count_wr`, `out_set_byte` and `out_count` are all zero.
- R3: Condition codes are encoded as 0=always true, 1=always false, 2=C=0 and Z=0, 3=C=1 or Z=1, 4=C=0, 5=C=1, 6=Z=0, 7=Z=1, 8=V=0, 9=V=1, 10=N=0, 11=N=1, 12=N equals V, 13=N differs from V, 14=N equals V and Z=0, 15=Z=1 or N differs from V.
- R4: For kind 0 (plain branch) with a code from 2 to 15, `out_taken` equals the condition of R3, and `out_illegal` is 0.
- R5: For kind 0 with code 0 or 1, `out_illegal` is 1 and `out_taken` is 0.
- R6: For kind 1 (conditional set), `out_set_byte` is 8'hFF when the condition holds and 8'h00 otherwise. `out_taken` and `out_illegal` are 0.
- R7: For kind 2 (counted loop), when the condition holds there is no decrement. `out_count_wr` is 0, `out_taken` is 0, and `out_count` equals `in_count`.
- R8: For kind 2, when the condition is false, bits 15:0 of the counter are decremented modulo 2^16 and bits 31:16 pass through unchanged. `out_count_wr` is 1, and `out_taken` is 1 unless the new low word is 16'hFFFF. A low word of 0 therefore wraps to 16'hFFFF and ends the loop.
- R9: Kind 3 is reserved. It gives `out_illegal` 1, with `out_taken`, `out_count_wr` and `out_set_byte` all 0, and `out_count` equal to `in_count`.
- R10: For kinds 0, 1 and 3, `out_count_wr` is 0 and `out_count` equals `in_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input qualifier |
| in_kind | input | 2 | 0 branch, 1 set, 2 loop, 3 reserved |
| in_cond | input | 4 | Condition code, encoding as in R3 |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| in_count | input | 32 | Counter register value |
| out_valid | output | 1 | Result present |
| out_taken | output | 1 | Branch taken |
| out_illegal | output | 1 | Code or kind not allowed |
| out_set_byte | output | 8 | Conditional-set result byte |
| out_count | output | 32 | Updated counter register |
| out_count_wr | output | 1 | Counter write-back strobe |

## Verification
A single result register sits between each input and its result, so any internal fault shows up at the ports one cycle after the input that exposes it. A wrong stage state appears as an `out_valid` pulse out of step with `in_valid`. A stale output register appears as nonzero fields after an idle cycle. A wrong predicate or decrement appears as a mismatched taken flag, set byte or counter on the very next cycle. The bench sweeps every kind, code and flag combination against counter values that include the wrap from zero and a borrow into the upper bits.

// File: rtl/ccbr_pkg.sv
package ccbr_pkg;

    localparam int unsigned COND_W = 4;
    localparam int unsigned KIND_W = 2;

    typedef enum logic [COND_W-1:0] {
        CC_T  = 4'd0,
        CC_F  = 4'd1,
        CC_HI = 4'd2,
        CC_LS = 4'd3,
        CC_CC = 4'd4,
        CC_CS = 4'd5,
        CC_NE = 4'd6,
        CC_EQ = 4'd7,
        CC_VC = 4'd8,
        CC_VS = 4'd9,
        CC_PL = 4'd10,
        CC_MI = 4'd11,
        CC_GE = 4'd12,
        CC_LT = 4'd13,
        CC_GT = 4'd14,
        CC_LE = 4'd15
    } cond_code_e;

    typedef enum logic [KIND_W-1:0] {
        KIND_BRANCH = 2'd0,
        KIND_SET    = 2'd1,
        KIND_LOOP   = 2'd2,
        KIND_RSVD   = 2'd3
    } op_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } stage_state_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } flag_set_t;

endpackage

// File: rtl/ccbr_cond_eval.sv
module ccbr_cond_eval
    import ccbr_pkg::*;
(
    input  flag_set_t  flags,
    input  cond_code_e code,
    output logic       holds,
    output logic       branch_ok
);

    logic sign_match;

    assign sign_match = (flags.neg == flags.ovf);

    always_comb begin
        unique case (code)
            CC_T:  holds = 1'b1;
            CC_F:  holds = 1'b0;
            CC_HI: holds = !flags.carry && !flags.zero;
            CC_LS: holds = flags.carry || flags.zero;
            CC_CC: holds = !flags.carry;
            CC_CS: holds = flags.carry;
            CC_NE: holds = !flags.zero;
            CC_EQ: holds = flags.zero;
            CC_VC: holds = !flags.ovf;
            CC_VS: holds = flags.ovf;
            CC_PL: holds = !flags.neg;
            CC_MI: holds = flags.neg;
            CC_GE: holds = sign_match;
            CC_LT: holds = !sign_match;
            CC_GT: holds = sign_match && !flags.zero;
            CC_LE: holds = flags.zero || !sign_match;
        endcase
    end

    // Constant codes are only legal for the set and loop kinds
    assign branch_ok = !(code inside {CC_T, CC_F});

endmodule

// File: rtl/ccbr_loop_step.sv
module ccbr_loop_step #(
    parameter int unsigned REG_W = 32,
    parameter int unsigned CNT_W = 16
) (
    input  logic [REG_W-1:0] count_in,
    input  logic             holds,
    output logic [REG_W-1:0] count_next,
    output logic             dec_en,
    output logic             loop_on
);

    localparam int unsigned HI_W = REG_W - CNT_W;
    localparam logic [CNT_W-1:0] STOP_VAL = '1;

    logic [CNT_W-1:0] low_cur;
    logic [CNT_W-1:0] low_dec;
    logic [CNT_W-1:0] low_sel;

    assign low_cur = count_in[CNT_W-1:0];
    assign low_dec = low_cur - CNT_W'(1);
    assign dec_en  = !holds;
    assign low_sel = dec_en ? low_dec : low_cur;
    assign loop_on = dec_en && (low_dec != STOP_VAL);

    generate
        if (HI_W > 0) begin : g_split
            assign count_next = {count_in[REG_W-1:CNT_W], low_sel};
        end else begin : g_whole
            assign count_next = low_sel;
        end
    endgenerate

endmodule

// File: rtl/ccbr_result_mux.sv
module ccbr_result_mux
    import ccbr_pkg::*;
#(
    parameter int unsigned REG_W = 32,
    parameter int unsigned SET_W = 8
) (
    input  op_kind_e         kind,
    input  logic             holds,
    input  logic             branch_ok,
    input  logic [REG_W-1:0] count_in,
    input  logic [REG_W-1:0] loop_count,
    input  logic             loop_dec,
    input  logic             loop_on,
    output logic             taken,
    output logic             illegal,
    output logic [SET_W-1:0] set_byte,
    output logic [REG_W-1:0] count_out,
    output logic             count_wr
);

    always_comb begin
        taken     = 1'b0;
        illegal   = 1'b0;
        set_byte  = '0;
        count_out = count_in;
        count_wr  = 1'b0;
        unique case (kind)
            KIND_BRANCH: begin
                taken   = holds && branch_ok;
                illegal = !branch_ok;
            end
            KIND_SET: begin
                set_byte = holds ? '1 : '0;
            end
            KIND_LOOP: begin
                taken     = loop_on;
                count_out = loop_count;
                count_wr  = loop_dec;
            end
            KIND_RSVD: begin
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ccbr_unit.sv
module ccbr_unit
    import ccbr_pkg::*;
#(
    parameter int unsigned REG_W = 32,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned SET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [3:0]       in_cond,
    input  logic             flag_n,
    input  logic             flag_z,
    input  logic             flag_v,
    input  logic             flag_c,
    input  logic [REG_W-1:0] in_count,
    output logic             out_valid,
    output logic             out_taken,
    output logic             out_illegal,
    output logic [SET_W-1:0] out_set_byte,
    output logic [REG_W-1:0] out_count,
    output logic             out_count_wr
);

    flag_set_t        flags;
    cond_code_e       code;
    op_kind_e         kind;
    logic             holds;
    logic             branch_ok;
    logic [REG_W-1:0] loop_count;
    logic             loop_dec;
    logic             loop_on;
    logic             res_taken;
    logic             res_illegal;
    logic [SET_W-1:0] res_set;
    logic [REG_W-1:0] res_count;
    logic             res_wr;
    stage_state_e     state_q;
    stage_state_e     state_d;

    assign flags = '{neg: flag_n, zero: flag_z, ovf: flag_v, carry: flag_c};
    assign code  = cond_code_e'(in_cond);
    assign kind  = op_kind_e'(in_kind);

    ccbr_cond_eval eval_i (
        .flags     (flags),
        .code      (code),
        .holds     (holds),
        .branch_ok (branch_ok)
    );

    ccbr_loop_step #(.REG_W(REG_W), .CNT_W(CNT_W)) step_i (
        .count_in   (in_count),
        .holds      (holds),
        .count_next (loop_count),
        .dec_en     (loop_dec),
        .loop_on    (loop_on)
    );

    ccbr_result_mux #(.REG_W(REG_W), .SET_W(SET_W)) mux_i (
        .kind       (kind),
        .holds      (holds),
        .branch_ok  (branch_ok),
        .count_in   (in_count),
        .loop_count (loop_count),
        .loop_dec   (loop_dec),
        .loop_on    (loop_on),
        .taken      (res_taken),
        .illegal    (res_illegal),
        .set_byte   (res_set),
        .count_out  (res_count),
        .count_wr   (res_wr)
    );

    // Next-state: GO_ISSUE on a valid input, GO_IDLE otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = in_valid ? ST_ISSUE : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_taken    <= 1'b0;
            out_illegal  <= 1'b0;
            out_set_byte <= '0;
            out_count    <= '0;
            out_count_wr <= 1'b0;
        end else if (in_valid) begin
            out_taken    <= res_taken;
            out_illegal  <= res_illegal;
            out_set_byte <= res_set;
            out_count    <= res_count;
            out_count_wr <= res_wr;
        end else begin
            out_taken    <= 1'b0;
            out_illegal  <= 1'b0;
            out_set_byte <= '0;
            out_count    <= '0;
            out_count_wr <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_ISSUE);

endmodule

// File: rtl/ccbr_unit_chk.sv
module ccbr_unit_chk #(
    parameter int unsigned REG_W = 32,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned SET_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       in_kind,
    input logic [3:0]       in_cond,
    input logic [REG_W-1:0] in_count,
    input logic             out_valid,
    input logic             out_taken,
    input logic             out_illegal,
    input logic [SET_W-1:0] out_set_byte,
    input logic [REG_W-1:0] out_count,
    input logic             out_count_wr
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_taken && !out_illegal && !out_count_wr
                       && out_set_byte == '0 && out_count == '0));

    // R5
    branch_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd0 && in_cond < 4'd2) |=> (out_illegal && !out_taken));

    // R6
    set_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd1) |=>
            ((out_set_byte == '1 || out_set_byte == '0) && !out_taken && !out_illegal));

    // R8
    loop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd2 && out_count_wr == 1'b0) |=>
            (out_count_wr
                ? (out_count[CNT_W-1:0] == CNT_W'($past(in_count[CNT_W-1:0]) - CNT_W'(1))
                   && out_count[REG_W-1:CNT_W] == $past(in_count[REG_W-1:CNT_W]))
                : (out_count == $past(in_count) && !out_taken)));

    // R8
    loop_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_count_wr |-> (out_taken == (out_count[CNT_W-1:0] != '1)));

    // R10
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind != 2'd2) |=> (!out_count_wr && out_count == $past(in_count)));

    // R9
    rsvd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd3) |=> (out_illegal && !out_taken && out_set_byte == '0));

endmodule

bind ccbr_unit ccbr_unit_chk #(.REG_W(REG_W), .CNT_W(CNT_W), .SET_W(SET_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_kind      (in_kind),
    .in_cond      (in_cond),
    .in_count     (in_count),
    .out_valid    (out_valid),
    .out_taken    (out_taken),
    .out_illegal  (out_illegal),
    .out_set_byte (out_set_byte),
    .out_count    (out_count),
    .out_count_wr (out_count_wr)
);

// File: tb/ccbr_unit_tb_top.sv
`timescale 1ns/1ps
module ccbr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_kind = '0;
    logic [3:0]  in_cond = '0;
    logic        flag_n = 1'b0;
    logic        flag_z = 1'b0;
    logic        flag_v = 1'b0;
    logic        flag_c = 1'b0;
    logic [31:0] in_count = '0;
    logic        out_valid;
    logic        out_taken;
    logic        out_illegal;
    logic [7:0]  out_set_byte;
    logic [31:0] out_count;
    logic        out_count_wr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ccbr_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_kind      (in_kind),
        .in_cond      (in_cond),
        .flag_n       (flag_n),
        .flag_z       (flag_z),
        .flag_v       (flag_v),
        .flag_c       (flag_c),
        .in_count     (in_count),
        .out_valid    (out_valid),
        .out_taken    (out_taken),
        .out_illegal  (out_illegal),
        .out_set_byte (out_set_byte),
        .out_count    (out_count),
        .out_count_wr (out_count_wr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Predicate from R3: even codes give a base test, odd codes its inverse
    function automatic bit pred(input int code, input bit n, input bit z, input bit v, input bit c);
        bit base;
        case (code / 2)
            0: base = 1'b1;
            1: base = !c && !z;
            2: base = !c;
            3: base = !z;
            4: base = !v;
            5: base = !n;
            6: base = (n == v);
            default: base = (n == v) && !z;
        endcase
        return (code % 2 == 1) ? !base : base;
    endfunction

    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0;
        in_kind  = 2'd2;
        in_cond  = 4'd1;
        in_count = 32'h5555_0003;
        @(negedge clk);
        chk("R2 valid", {31'd0, out_valid}, 32'd0);
        chk("R2 taken", {31'd0, out_taken}, 32'd0);
        chk("R2 illegal", {31'd0, out_illegal}, 32'd0);
        chk("R2 wr", {31'd0, out_count_wr}, 32'd0);
        chk("R2 set", {24'd0, out_set_byte}, 32'd0);
        chk("R2 count", out_count, 32'd0);
    endtask

    initial begin
        logic [31:0] cnt_list [4];
        cnt_list[0] = 32'h1234_0000;
        cnt_list[1] = 32'hABCD_0001;
        cnt_list[2] = 32'h0000_0005;
        cnt_list[3] = 32'hFFFF_FFFF;

        repeat (3) @(negedge clk);
        // R1: outputs zero under reset
        chk("R1 valid", {31'd0, out_valid}, 32'd0);
        chk("R1 taken", {31'd0, out_taken}, 32'd0);
        chk("R1 illegal", {31'd0, out_illegal}, 32'd0);
        chk("R1 set", {24'd0, out_set_byte}, 32'd0);
        chk("R1 count", out_count, 32'd0);
        chk("R1 wr", {31'd0, out_count_wr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 4; k++) begin
            for (int cd = 0; cd < 16; cd++) begin
                for (int f = 0; f < 16; f++) begin
                    for (int ci = 0; ci < 4; ci++) begin
                        bit          p;
                        bit          e_taken;
                        bit          e_ill;
                        bit          e_wr;
                        logic [7:0]  e_set;
                        logic [31:0] e_cnt;
                        logic [15:0] nlow;
                        string       t_tag;
                        string       c_tag;

                        in_valid = 1'b1;
                        in_kind  = k[1:0];
                        in_cond  = cd[3:0];
                        flag_n   = f[3];
                        flag_z   = f[2];
                        flag_v   = f[1];
                        flag_c   = f[0];
                        in_count = cnt_list[ci];

                        p       = pred(cd, f[3], f[2], f[1], f[0]);
                        e_taken = 1'b0;
                        e_ill   = 1'b0;
                        e_wr    = 1'b0;
                        e_set   = 8'h00;
                        e_cnt   = cnt_list[ci];
                        c_tag   = "R10 count";
                        case (k)
                            0: begin
                                e_ill   = (cd < 2);
                                e_taken = p && (cd >= 2);
                                t_tag   = (cd < 2) ? "R5 branch" : "R4 branch";
                            end
                            1: begin
                                e_set = p ? 8'hFF : 8'h00;
                                t_tag = "R3 R6 set";
                            end
                            2: begin
                                if (p) begin
                                    t_tag = "R7 loop hold";
                                    c_tag = "R7 count";
                                end else begin
                                    nlow    = 16'((32'(cnt_list[ci][15:0]) + 32'hFFFF) % 32'h1_0000);
                                    e_cnt   = {cnt_list[ci][31:16], nlow};
                                    e_wr    = 1'b1;
                                    e_taken = (nlow != 16'hFFFF);
                                    t_tag   = "R8 loop dec";
                                    c_tag   = "R8 count";
                                end
                            end
                            default: begin
                                e_ill = 1'b1;
                                t_tag = "R9 reserved";
                            end
                        endcase

                        @(negedge clk);
                        chk("R2 valid", {31'd0, out_valid}, 32'd1);
                        chk(t_tag, {31'd0, out_taken}, {31'd0, e_taken});
                        chk(t_tag, {31'd0, out_illegal}, {31'd0, e_ill});
                        chk(t_tag, {24'd0, out_set_byte}, {24'd0, e_set});
                        chk(c_tag, out_count, e_cnt);
                        chk(c_tag, {31'd0, out_count_wr}, {31'd0, e_wr});
                    end
                end
                if (cd % 4 == 3) idle_check();
            end
        end

        idle_check();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule